// File: doc/BRIEF.md
# Sample rate classifier

This block estimates the sample rate of a received audio stream by counting cycles of a fixed 6.144 MHz reference clock across a run of received frames. It then sorts the count into a 3-bit code. The code separates tight matches (±400 ppm) from loose matches (±4%) for the common rates, and it also recognises 44.056 kHz.

The block runs in the reference clock domain. A frame strobe and a block-start flag come from the receiver. They pass through a two-flop synchroniser, and each rising edge of the frame strobe marks one received frame. A measurement window opens on a frame that carries the block-start flag. It closes after a fixed number of further frames; the default is 128, which is two thirds of a 192-frame block.

When the window closes, the code is published and a valid flag is raised. The code is then held until the next window closes. If the reference-valid input drops, the valid flag is cleared at once and any window in progress is thrown away.

Top module: `srate_classifier`

## Requirements
- R1: After a synchronous reset the code output is 000 and the valid flag is low.
- R2: A window opens only on a frame rising edge that carries the block flag while `ref_good` is high. The window closes on the WIN_FRAMES-th frame edge that follows. Its count is the number of reference cycles between the opening edge and the closing edge. Frames that arrive without a block flag while no window is open start nothing.
- R3: For each rate, nom = round(REF_HZ*WIN_FRAMES/rate) and tol = floor(nom*ppm/1e6). A count with |count−nom| <= tol at 400 ppm gives a fine code: 100 for 48 kHz, 101 for 44.1 kHz, 110 for 44.056 kHz, 111 for 32 kHz.
- R4: When no fine band matches, a count within the 4% band gives a coarse code: 001 for 48 kHz, 010 for 44.1 kHz, 011 for 32 kHz. Because fine bands are checked first, a count in the 44.056 kHz fine band reports 110, even though it also lies in the 44.1 kHz coarse band.
- R5: A count that lies outside every band gives code 000, and the valid flag is still raised.
- R6: Code and valid update on the fourth rising reference edge after the closing frame strobe rises. They are then held unchanged through later frames until the next window closes.
- R7: While `ref_good` is low, the valid flag goes low on the next edge and the code keeps its value. Any open window is discarded, so a new block flag is needed before the next result.
- R8: A block flag that arrives inside an open window restarts the window from that frame. The partial count is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | 6.144 MHz reference clock |
| rst | input | 1 | synchronous active-high reset |
| ref_good | input | 1 | reference clock is trustworthy (reference domain) |
| frame_in | input | 1 | frame strobe from the receiver; one rising edge per frame, high for at least one reference cycle |
| block_in | input | 1 | block-start flag, held together with the frame strobe it qualifies |
| rate_code | output | 3 | sample rate classification code |
| rate_valid | output | 1 | rate_code holds a result from a complete window |

## Verification
The checker watches four things on every cycle: `rate_valid` falls after `ref_good` drops, `rate_code` never moves without a window-complete pulse, `rate_valid` rises only after such a pulse, and completion is never reported while the reference is invalid. Other behaviour can only be shown by bench scenarios. These are the band edges on both sides of each fine and coarse limit, the precedence of the 44.056 kHz fine band over the 44.1 kHz coarse band, the four-edge publish latency, restart on a mid-window block flag, and discarding of a window interrupted by a reference loss.

// File: rtl/srate_pkg.sv
package srate_pkg;

    typedef enum logic [2:0] {
        RC_NONE   = 3'b000,
        RC_C48    = 3'b001,
        RC_C441   = 3'b010,
        RC_C32    = 3'b011,
        RC_F48    = 3'b100,
        RC_F441   = 3'b101,
        RC_F44056 = 3'b110,
        RC_F32    = 3'b111
    } rate_code_e;

    typedef enum logic {
        WS_IDLE = 1'b0,
        WS_MEAS = 1'b1
    } win_state_e;

    localparam int NUM_RATES = 4;

    localparam longint unsigned RATE_HZ [NUM_RATES] = '{48000, 44100, 44056, 32000};
    localparam rate_code_e FINE_CODE [NUM_RATES] = '{RC_F48, RC_F441, RC_F44056, RC_F32};
    localparam rate_code_e COARSE_CODE [NUM_RATES] = '{RC_C48, RC_C441, RC_NONE, RC_C32};
    localparam bit HAS_COARSE [NUM_RATES] = '{1'b1, 1'b1, 1'b0, 1'b1};

    typedef struct packed {
        logic [NUM_RATES-1:0] fine;
        logic [NUM_RATES-1:0] coarse;
    } band_hits_t;

    function automatic longint unsigned nominal_count(longint unsigned ref_hz,
                                                      longint unsigned frames,
                                                      longint unsigned rate_hz);
        return (ref_hz * frames + rate_hz / 2) / rate_hz;
    endfunction

    function automatic longint unsigned band_tol(longint unsigned nom, longint unsigned ppm);
        return (nom * ppm) / 64'd1000000;
    endfunction

    function automatic int count_width(longint unsigned ref_hz, longint unsigned frames);
        longint unsigned slowest;
        slowest = RATE_HZ[0];
        for (int i = 1; i < NUM_RATES; i++) begin
            if (RATE_HZ[i] < slowest) slowest = RATE_HZ[i];
        end
        return $clog2(2 * nominal_count(ref_hz, frames, slowest)) + 1;
    endfunction

endpackage

// File: rtl/srate_edge_sync.sv
module srate_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_raw,
    input  logic block_raw,
    output logic frame_rise,
    output logic block_flag
);
    localparam int LAST_STAGE = SYNC_STAGES - 1;

    logic [1:0] pipe [SYNC_STAGES];
    logic       frame_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SYNC_STAGES; s++) pipe[s] <= 2'b00;
            frame_prev <= 1'b0;
        end else begin
            pipe[0] <= {block_raw, frame_raw};
            for (int s = 1; s < SYNC_STAGES; s++) pipe[s] <= pipe[s-1];
            frame_prev <= pipe[LAST_STAGE][0];
        end
    end

    assign frame_rise = pipe[LAST_STAGE][0] & ~frame_prev;
    assign block_flag = pipe[LAST_STAGE][1];

endmodule

// File: rtl/srate_window.sv
module srate_window
    import srate_pkg::*;
#(
    parameter int WIN_FRAMES = 128,
    parameter int CNT_W      = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_good,
    input  logic             frame_rise,
    input  logic             block_flag,
    output logic             done,
    output logic [CNT_W-1:0] count
);
    localparam int              FRM_W = (WIN_FRAMES > 2) ? $clog2(WIN_FRAMES) : 1;
    localparam logic [FRM_W-1:0] LAST = FRM_W'(WIN_FRAMES - 1);
    localparam logic [CNT_W-1:0] CMAX = '1;

    win_state_e       state;
    logic [FRM_W-1:0] frames_seen;
    logic [CNT_W-1:0] cycles;
    logic [CNT_W-1:0] cycles_next;
    logic             closing;

    // saturating count so a stalled stream cannot wrap into a band
    assign cycles_next = (cycles == CMAX) ? cycles : cycles + 1'b1;
    assign closing     = frame_rise && (state == WS_MEAS) && (frames_seen == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= WS_IDLE;
            frames_seen <= '0;
            cycles      <= '0;
            done        <= 1'b0;
            count       <= '0;
        end else begin
            done <= 1'b0;
            if (!ref_good) begin
                state       <= WS_IDLE;
                frames_seen <= '0;
            end else begin
                if (state == WS_MEAS) cycles <= cycles_next;
                if (closing) begin
                    done        <= 1'b1;
                    count       <= cycles_next;
                    state       <= WS_IDLE;
                    frames_seen <= '0;
                end else if (frame_rise && state == WS_MEAS) begin
                    frames_seen <= frames_seen + 1'b1;
                end
                // a block start opens a window, or restarts an open one
                if (frame_rise && block_flag) begin
                    state       <= WS_MEAS;
                    cycles      <= '0;
                    frames_seen <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/srate_classify.sv
module srate_classify
    import srate_pkg::*;
#(
    parameter longint unsigned REF_HZ     = 6144000,
    parameter int              WIN_FRAMES = 128,
    parameter longint unsigned FINE_PPM   = 400,
    parameter longint unsigned COARSE_PPM = 40000,
    parameter int              CNT_W      = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_good,
    input  logic             done,
    input  logic [CNT_W-1:0] count,
    output rate_code_e       code,
    output logic             valid
);
    band_hits_t hits;
    rate_code_e next_code;

    for (genvar i = 0; i < NUM_RATES; i++) begin : g_band
        localparam longint unsigned NOM = nominal_count(REF_HZ, WIN_FRAMES, RATE_HZ[i]);
        localparam longint unsigned FT  = band_tol(NOM, FINE_PPM);
        localparam longint unsigned CT  = band_tol(NOM, COARSE_PPM);
        localparam logic [CNT_W-1:0] F_LO = CNT_W'(NOM - FT);
        localparam logic [CNT_W-1:0] F_HI = CNT_W'(NOM + FT);
        localparam logic [CNT_W-1:0] C_LO = CNT_W'(NOM - CT);
        localparam logic [CNT_W-1:0] C_HI = CNT_W'(NOM + CT);

        assign hits.fine[i]   = (count >= F_LO) && (count <= F_HI);
        assign hits.coarse[i] = (count >= C_LO) && (count <= C_HI) && HAS_COARSE[i];
    end

    always_comb begin
        next_code = RC_NONE;
        for (int i = NUM_RATES - 1; i >= 0; i--) begin
            if (hits.coarse[i]) next_code = COARSE_CODE[i];
        end
        // fine bands override any coarse match
        for (int i = NUM_RATES - 1; i >= 0; i--) begin
            if (hits.fine[i]) next_code = FINE_CODE[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code  <= RC_NONE;
            valid <= 1'b0;
        end else begin
            if (done) code <= next_code;
            if (!ref_good)  valid <= 1'b0;
            else if (done)  valid <= 1'b1;
        end
    end

endmodule

// File: rtl/srate_classifier.sv
module srate_classifier
    import srate_pkg::*;
#(
    parameter longint unsigned REF_HZ      = 6144000,
    parameter int              WIN_FRAMES  = 128,
    parameter longint unsigned FINE_PPM    = 400,
    parameter longint unsigned COARSE_PPM  = 40000,
    parameter int              SYNC_STAGES = 2
) (
    input  logic       clk_ref,
    input  logic       rst,
    input  logic       ref_good,
    input  logic       frame_in,
    input  logic       block_in,
    output logic [2:0] rate_code,
    output logic       rate_valid
);
    localparam int CNT_W = count_width(REF_HZ, WIN_FRAMES);

    logic             frame_rise;
    logic             block_flag;
    logic             win_done;
    logic [CNT_W-1:0] win_count;
    rate_code_e       code_q;

    srate_edge_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk        (clk_ref),
        .rst        (rst),
        .frame_raw  (frame_in),
        .block_raw  (block_in),
        .frame_rise (frame_rise),
        .block_flag (block_flag)
    );

    srate_window #(
        .WIN_FRAMES(WIN_FRAMES),
        .CNT_W     (CNT_W)
    ) u_window (
        .clk        (clk_ref),
        .rst        (rst),
        .ref_good   (ref_good),
        .frame_rise (frame_rise),
        .block_flag (block_flag),
        .done       (win_done),
        .count      (win_count)
    );

    srate_classify #(
        .REF_HZ    (REF_HZ),
        .WIN_FRAMES(WIN_FRAMES),
        .FINE_PPM  (FINE_PPM),
        .COARSE_PPM(COARSE_PPM),
        .CNT_W     (CNT_W)
    ) u_classify (
        .clk      (clk_ref),
        .rst      (rst),
        .ref_good (ref_good),
        .done     (win_done),
        .count    (win_count),
        .code     (code_q),
        .valid    (rate_valid)
    );

    assign rate_code = code_q;

endmodule

// File: rtl/srate_classifier_chk.sv
module srate_classifier_chk (
    input logic       clk,
    input logic       rst,
    input logic       ref_good,
    input logic       win_done,
    input logic [2:0] rate_code,
    input logic       rate_valid
);

    // R7: losing the reference clears the valid flag on the next edge
    p_valid_drop_r7: assert property (@(posedge clk) disable iff (rst)
        !ref_good |=> !rate_valid);

    // R6: the code only moves on a window-complete pulse
    p_code_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !win_done |=> $stable(rate_code));

    // R6: valid only rises after a completed window
    p_valid_source_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(rate_valid) |-> $past(win_done));

    // R7: no window completes while the reference is untrusted
    p_done_needs_ref_r7: assert property (@(posedge clk) disable iff (rst)
        win_done |-> $past(ref_good));

    // R1: outputs are always driven to known values
    p_outputs_known_r1: assert property (@(posedge clk) disable iff (rst)
        !$isunknown({rate_code, rate_valid}));

endmodule

bind srate_classifier srate_classifier_chk u_chk (
    .clk        (clk_ref),
    .rst        (rst),
    .ref_good   (ref_good),
    .win_done   (win_done),
    .rate_code  (rate_code),
    .rate_valid (rate_valid)
);

// File: tb/srate_classifier_test.sv
module srate_classifier_test;

    localparam int WIN = 32;
    localparam int NV  = 24;

    // window lengths in reference cycles and the codes they must produce (WIN = 32)
    localparam int VT [NV] = '{
        4096, 4097, 4098, 4095, 4094, 3933, 3932, 4259, 4260,
        4458, 4459, 4460, 4463, 4462, 4464, 4465, 4636, 4637,
        6144, 6146, 6147, 6389, 6390, 5000
    };
    localparam logic [2:0] VC [NV] = '{
        3'b100, 3'b100, 3'b001, 3'b100, 3'b001, 3'b001, 3'b000, 3'b001, 3'b000,
        3'b101, 3'b101, 3'b010, 3'b110, 3'b110, 3'b110, 3'b010, 3'b010, 3'b000,
        3'b111, 3'b111, 3'b011, 3'b011, 3'b000, 3'b000
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_good = 1'b1;
    logic       frame_in = 1'b0;
    logic       block_in = 1'b0;
    logic [2:0] rate_code;
    logic       rate_valid;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    srate_classifier #(
        .WIN_FRAMES(WIN)
    ) uut (
        .clk_ref    (clk),
        .rst        (rst),
        .ref_good   (ref_good),
        .frame_in   (frame_in),
        .block_in   (block_in),
        .rate_code  (rate_code),
        .rate_valid (rate_valid)
    );

    task automatic check(string tag, int act, int exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // one frame strobe, then idle until gap cycles after its rising edge
    task automatic frame(bit blk, int gap);
        frame_in = 1'b1;
        block_in = blk;
        @(negedge clk);
        frame_in = 1'b0;
        block_in = 1'b0;
        repeat (gap - 1) @(negedge clk);
    endtask

    // full window of total cycles; optionally checks the publish latency
    task automatic run_window(int total, bit chk_lat);
        int v3;
        int v4;
        for (int i = 0; i < WIN; i++) begin
            frame(i == 0, ((i + 1) * total) / WIN - (i * total) / WIN);
        end
        frame_in = 1'b1;
        @(negedge clk);
        frame_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        v3 = int'(rate_valid);
        @(negedge clk);
        v4 = int'(rate_valid);
        if (chk_lat) begin
            check("R6", v3, 0, "valid before fourth edge");
            check("R6", v4, 1, "valid at fourth edge");
        end
        repeat (16) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (5) @(negedge clk);
        // R1: reset state
        check("R1", int'(rate_code), 0, "code after reset");
        check("R1", int'(rate_valid), 0, "valid after reset");
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R2: frames without a block flag start nothing
        for (int i = 0; i < 40; i++) frame(1'b0, 130);
        check("R2", int'(rate_valid), 0, "valid after unflagged frames");

        // R3 fine, R4 coarse and precedence, R5 out of range
        for (int v = 0; v < NV; v++) begin
            run_window(VT[v], v == 0);
            if (VC[v][2])
                check("R3", int'(rate_code), int'(VC[v]), $sformatf("fine code, count %0d", VT[v]));
            else if (VC[v] == 3'b000)
                check("R5", int'(rate_code), int'(VC[v]), $sformatf("no band, count %0d", VT[v]));
            else
                check("R4", int'(rate_code), int'(VC[v]), $sformatf("coarse code, count %0d", VT[v]));
            check("R2", int'(rate_valid), 1, $sformatf("valid after window %0d", VT[v]));
        end

        // R6: code held through frames between windows
        run_window(4096, 1'b0);
        for (int i = 0; i < 20; i++) frame(1'b0, 128);
        check("R6", int'(rate_code), 3'b100, "code held between windows");
        check("R6", int'(rate_valid), 1, "valid held between windows");

        // R8: block flag inside an open window restarts it
        frame(1'b1, 128);
        for (int i = 0; i < 10; i++) frame(1'b0, 128);
        run_window(6144, 1'b0);
        check("R8", int'(rate_code), 3'b111, "code after restarted window");

        // R7: reference loss mid-window
        frame(1'b1, 128);
        for (int i = 0; i < 10; i++) frame(1'b0, 128);
        ref_good = 1'b0;
        @(negedge clk);
        check("R7", int'(rate_valid), 0, "valid one edge after reference loss");
        check("R7", int'(rate_code), 3'b111, "code held on reference loss");
        repeat (4) @(negedge clk);
        ref_good = 1'b1;
        for (int i = 0; i < 30; i++) frame(1'b0, 128);
        check("R7", int'(rate_valid), 0, "interrupted window discarded");
        check("R7", int'(rate_code), 3'b111, "code untouched by discarded window");
        run_window(4458, 1'b0);
        check("R7", int'(rate_code), 3'b101, "code after recovery window");
        check("R7", int'(rate_valid), 1, "valid after recovery window");

        // R2: block flag seen while reference is bad opens no window
        ref_good = 1'b0;
        frame(1'b1, 128);
        ref_good = 1'b1;
        for (int i = 0; i < 34; i++) frame(1'b0, 128);
        check("R2", int'(rate_valid), 0, "no window from flag under bad reference");
        check("R2", int'(rate_code), 3'b101, "code unchanged without a window");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule